// File: doc/BRIEF.md
# Cell-Committing Dual-Clock Octet FIFO

This block carries octets of fixed-size cells from a writer on one clock to a reader on an unrelated clock. The writer treats each cell as a transaction. Octets go into storage at once, but the reader cannot see them until the writer commits the cell. If the writer aborts the cell, for example after finding a parity or length fault, every octet written since the last commit is thrown away by moving the write pointer back. The reader therefore only ever sees whole, good cells.

Each side has one flow-control flag for a cell-level handshake. On the write side, `wr_room` says that a full cell of the configured size still fits; octets of a cell in progress count as used space. On the read side, `rd_cell_avail` says that at least one whole committed cell is waiting. The cell size is a static input shared by both sides.

Pointers cross between the clock domains as Gray code through two-flop synchronizers. The committed pointer is not sent across directly. A published copy follows it one step per write clock, so the Gray value seen by the read side never changes by more than one bit per write clock. Each domain has its own asynchronous active-low reset, which is released synchronously inside the block.

Top module: `cell_commit_fifo`

## Requirements
- R1: After both resets are released, and given `cell_size` no larger than the depth, `wr_room` is 1 and `rd_cell_avail` is 0.
- R2: Octets written but not yet committed never make `rd_cell_avail` assert, however long the reader waits.
- R3: A commit makes its octets visible to the reader within one write clock per committed octet plus three read clocks. `rd_cell_avail` is 1 whenever the committed but unread octet count is at least `cell_size`.
- R4: `rd_data` always shows the oldest unread committed octet. Each read clock with `rd_en` high and data stored moves on by one octet, in write order.
- R5: `wr_abort` discards every octet written since the last commit. In its cycle it overrides `wr_en` and `wr_commit`, so nothing is written and nothing is committed.
- R6: `wr_room` equals (depth − (written octets, including uncommitted ones − octets read as seen on the write side)) ≥ `cell_size`.
- R7: A write when the store holds depth octets (committed or not) is dropped and changes neither the store nor any pointer.
- R8: `rd_en` while nothing committed is unread has no effect on the read pointer.
- R9: `wr_commit` in the same cycle as an accepted write includes that octet in the committed cell. `wr_commit` alone commits everything written so far.
- R10: `rd_cell_avail` falls as soon as a read leaves fewer than `cell_size` committed octets, and it is 0 whenever nothing committed is unread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cell_size | input | SIZE_W | Static cell length in octets, shared by both sides |
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_en | input | 1 | Write one octet this cycle |
| wr_data | input | DATA_W | Octet to write |
| wr_commit | input | 1 | Make all octets written so far visible to the reader |
| wr_abort | input | 1 | Discard all octets written since the last commit |
| wr_room | output | 1 | Space for one whole cell remains |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_en | input | 1 | Advance to the next octet |
| rd_data | output | DATA_W | Oldest unread committed octet |
| rd_cell_avail | output | 1 | At least one whole committed cell is stored |

## Verification
A working pointer that rolls back wrongly shows at the ports within one cell: the reader gets the wrong octets after an abort, or `wr_room` disagrees with the octet count the bench keeps. A published pointer that runs ahead of the commit, or a sync path that keeps stale values, shows as `rd_cell_avail` rising before a commit or staying low after one, within the fixed settle window the bench waits. Faults in the read pointer or the full check show as a mismatched first octet of the next cell, so a full-store write or an empty-store read is always followed by a data read-back.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
  // Fixed working width for pointer arithmetic; pointer widths must not exceed it.
  localparam int unsigned GW = 16;
  typedef logic [GW-1:0] gvec_t;

  function automatic gvec_t to_gray(input gvec_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic gvec_t from_gray(input gvec_t g);
    gvec_t b;
    b[GW-1] = g[GW-1];
    for (int i = GW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/cfifo_rst_sync.sv
module cfifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/cfifo_sync.sv
module cfifo_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/cfifo_mem.sv
module cfifo_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 11
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store_q[waddr] <= wdata;
  end

  assign rdata = store_q[raddr];
endmodule

// File: rtl/cfifo_wr_ctrl.sv
module cfifo_wr_ctrl
  import cfifo_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              commit,
  input  logic              abort,
  input  logic [SIZE_W-1:0] cell_size,
  input  logic [ADDR_W:0]   rgray_sync,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   pub_gray,
  output logic              room
);
  localparam int unsigned PW  = ADDR_W + 1;
  localparam gvec_t       CAP = gvec_t'(1) << ADDR_W;

  logic [PW-1:0] wptr_q, wptr_d;   // working pointer, speculative
  logic [PW-1:0] cptr_q, cptr_d;   // committed pointer
  logic [PW-1:0] pptr_q, pptr_d;   // published pointer, chases cptr by one
  logic [PW-1:0] pgray_q;
  logic [PW-1:0] rptr_b, used;
  logic          full, w_ce, c_ce, p_ce;

  assign rptr_b = PW'(from_gray(gvec_t'(rgray_sync)));
  assign used   = wptr_q - rptr_b;
  assign full   = used[PW-1];
  assign we     = wr_en & ~abort & ~full;
  assign waddr  = wptr_q[ADDR_W-1:0];
  assign room   = (CAP - gvec_t'(used)) >= gvec_t'(cell_size);

  always_comb begin
    wptr_d = wptr_q + PW'(we);
    if (abort) wptr_d = cptr_q;
    cptr_d = wptr_d;
    pptr_d = pptr_q + PW'(1);
    w_ce   = we | abort;
    c_ce   = commit & ~abort;
    p_ce   = (pptr_q != cptr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      cptr_q  <= '0;
      pptr_q  <= '0;
      pgray_q <= '0;
    end else begin
      if (w_ce) wptr_q <= wptr_d;
      if (c_ce) cptr_q <= cptr_d;
      if (p_ce) begin
        pptr_q  <= pptr_d;
        pgray_q <= PW'(to_gray(gvec_t'(pptr_d)));
      end
    end
  end

  assign pub_gray = pgray_q;
endmodule

// File: rtl/cfifo_rd_ctrl.sv
module cfifo_rd_ctrl
  import cfifo_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [SIZE_W-1:0] cell_size,
  input  logic [ADDR_W:0]   cgray_sync,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rgray,
  output logic              avail
);
  localparam int unsigned PW = ADDR_W + 1;

  logic [PW-1:0] rptr_q, rptr_d, rgray_q;
  logic [PW-1:0] cptr_b, stored;
  logic          pop;

  assign cptr_b = PW'(from_gray(gvec_t'(cgray_sync)));
  assign stored = cptr_b - rptr_q;
  assign pop    = rd_en & (stored != '0);
  assign avail  = gvec_t'(stored) >= gvec_t'(cell_size);
  assign raddr  = rptr_q[ADDR_W-1:0];

  always_comb begin
    rptr_d = rptr_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q  <= '0;
      rgray_q <= '0;
    end else if (pop) begin
      rptr_q  <= rptr_d;
      rgray_q <= PW'(to_gray(gvec_t'(rptr_d)));
    end
  end

  assign rgray = rgray_q;
endmodule

// File: rtl/cell_commit_fifo.sv
module cell_commit_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned SIZE_W = 8
) (
  input  logic [SIZE_W-1:0] cell_size,
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_commit,
  input  logic              wr_abort,
  output logic              wr_room,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_cell_avail
);
  localparam int unsigned PW = ADDR_W + 1;

  logic              wr_srst_n, rd_srst_n;
  logic              wr_we;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [PW-1:0]     pub_gray, pub_gray_rs, rd_gray, rd_gray_ws;

  cfifo_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(wr_rst_n), .srst_n(wr_srst_n));
  cfifo_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rd_rst_n), .srst_n(rd_srst_n));

  cfifo_wr_ctrl #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_wr (
    .clk(wr_clk), .rst_n(wr_srst_n), .wr_en(wr_en), .commit(wr_commit),
    .abort(wr_abort), .cell_size(cell_size), .rgray_sync(rd_gray_ws),
    .we(wr_we), .waddr(wr_addr), .pub_gray(pub_gray), .room(wr_room)
  );

  cfifo_sync #(.W(PW)) u_pub_to_rd (
    .clk(rd_clk), .rst_n(rd_srst_n), .d(pub_gray), .q(pub_gray_rs)
  );

  cfifo_sync #(.W(PW)) u_rd_to_wr (
    .clk(wr_clk), .rst_n(wr_srst_n), .d(rd_gray), .q(rd_gray_ws)
  );

  cfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk(wr_clk), .we(wr_we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  cfifo_rd_ctrl #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_rd (
    .clk(rd_clk), .rst_n(rd_srst_n), .rd_en(rd_en), .cell_size(cell_size),
    .cgray_sync(pub_gray_rs), .raddr(rd_addr), .rgray(rd_gray),
    .avail(rd_cell_avail)
  );
endmodule

// File: rtl/cfifo_checker.sv
module cfifo_checker #(
  parameter int unsigned PW = 12
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          wr_we,
  input logic          wr_abort,
  input logic [PW-1:0] pub_gray,
  input logic [PW-1:0] pub_gray_rs,
  input logic [PW-1:0] rd_gray,
  input logic          rd_cell_avail
);
  // R3: published committed pointer moves one Gray step at most per write clock
  p_pub_onestep_r3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(pub_gray ^ $past(pub_gray)) <= 1);

  // R4: read pointer moves one Gray step at most per read clock
  p_rd_onestep_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);

  // R5: an abort cycle never writes storage
  p_abort_no_write_r5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_abort |-> !wr_we);

  // R8: read pointer holds while nothing committed is unread
  p_no_pop_when_empty_r8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (pub_gray_rs == rd_gray) |=> $stable(rd_gray));

  // R10: no cell reported while nothing committed is unread
  p_empty_no_cell_r10: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (pub_gray_rs == rd_gray) |-> !rd_cell_avail);
endmodule

bind cell_commit_fifo cfifo_checker #(.PW(ADDR_W + 1)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
  .wr_we(wr_we), .wr_abort(wr_abort), .pub_gray(pub_gray),
  .pub_gray_rs(pub_gray_rs), .rd_gray(rd_gray), .rd_cell_avail(rd_cell_avail)
);

// File: tb/sim_cell_commit_fifo.sv
module sim_cell_commit_fifo;
  localparam int unsigned AW  = 6;
  localparam int unsigned DEP = 1 << AW;

  logic [7:0] cell_size;
  logic       wr_clk, wr_rst_n, wr_en, wr_commit, wr_abort, wr_room;
  logic [7:0] wr_data;
  logic       rd_clk, rd_rst_n, rd_en, rd_cell_avail;
  logic [7:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  cell_commit_fifo #(.DATA_W(8), .ADDR_W(AW), .SIZE_W(8)) u0 (
    .cell_size(cell_size), .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .wr_commit(wr_commit), .wr_abort(wr_abort),
    .wr_room(wr_room), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
    .rd_data(rd_data), .rd_cell_avail(rd_cell_avail)
  );

  initial wr_clk = 0;
  always #2.5 wr_clk = ~wr_clk;
  initial rd_clk = 0;
  always #3.5 rd_clk = ~rd_clk;

  function automatic logic [7:0] pat(input int id, input int i);
    return 8'((id * 37 + i * 5 + 3) & 255);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wput(input logic [7:0] d, input logic c);
    @(negedge wr_clk);
    wr_en = 1; wr_data = d; wr_commit = c; wr_abort = 0;
  endtask

  task automatic widle();
    @(negedge wr_clk);
    wr_en = 0; wr_commit = 0; wr_abort = 0;
  endtask

  task automatic wcell(input int id, input int n, input logic commit_last);
    for (int i = 0; i < n; i++) wput(pat(id, i), commit_last && (i == n - 1));
    widle();
  endtask

  task automatic rget(input logic [7:0] exp, input string req);
    @(negedge rd_clk);
    chk(req, "rd_data", 32'(rd_data), 32'(exp));
    rd_en = 1;
  endtask

  task automatic ridle();
    @(negedge rd_clk);
    rd_en = 0;
  endtask

  task automatic settle();
    repeat (100) @(negedge rd_clk);
  endtask

  task automatic rcell(input int id, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      rget(pat(id, i), req);
      if (i == 1) chk("R10", "avail after first read", 32'(rd_cell_avail), 0);
    end
    ridle();
  endtask

  initial begin
    repeat (100000) @(posedge wr_clk);
    if (!done) begin
      fails++;
      $display("FAIL R4 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    cell_size = 8'd16;
    wr_rst_n = 0; rd_rst_n = 0;
    wr_en = 0; wr_commit = 0; wr_abort = 0; wr_data = 0; rd_en = 0;
    repeat (5) @(negedge rd_clk);
    wr_rst_n = 1; rd_rst_n = 1;
    settle();
    chk("R1", "wr_room", 32'(wr_room), 1);
    chk("R1", "rd_cell_avail", 32'(rd_cell_avail), 0);

    // R2 / R9: uncommitted cell stays hidden; a bare commit publishes it
    wcell(1, 16, 0);
    settle();
    chk("R2", "avail before commit", 32'(rd_cell_avail), 0);
    @(negedge wr_clk); wr_commit = 1;
    widle();
    settle();
    chk("R3", "avail after commit", 32'(rd_cell_avail), 1);
    rcell(1, 16, "R4");
    settle();
    chk("R10", "avail after drain", 32'(rd_cell_avail), 0);

    // R9: commit together with last write
    wcell(2, 16, 1);
    settle();
    chk("R9", "avail", 32'(rd_cell_avail), 1);
    rcell(2, 16, "R9");
    settle();

    // R5: abort discards partial cell
    wcell(3, 10, 0);
    @(negedge wr_clk); wr_abort = 1;
    widle();
    wcell(4, 16, 1);
    settle();
    rcell(4, 16, "R5");
    settle();
    // R5: abort overrides write and commit in the same cycle
    wcell(5, 5, 0);
    @(negedge wr_clk); wr_en = 1; wr_data = 8'h55; wr_commit = 1; wr_abort = 1;
    widle();
    settle();
    chk("R5", "avail after abort+commit", 32'(rd_cell_avail), 0);
    wcell(6, 16, 1);
    settle();
    rcell(6, 16, "R5");
    settle();

    // R6: room tracks working pointer
    for (int k = 0; k < 3; k++) begin
      wcell(10 + k, 16, 1);
      chk("R6", "room after whole cells", 32'(wr_room), 1);
    end
    wput(pat(13, 0), 0);
    widle();
    chk("R6", "room with partial cell", 32'(wr_room), 0);
    for (int i = 1; i < 16; i++) wput(pat(13, i), i == 15);
    widle();
    chk("R6", "room when full", 32'(wr_room), 0);

    // R7: write into full store is dropped
    wput(8'hEE, 1);
    widle();
    settle();
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 16; i++) rget(pat(10 + k, i), "R7");
    ridle();
    settle();
    chk("R7", "room after drain", 32'(wr_room), 1);
    wcell(14, 15, 1);
    settle();
    chk("R7", "avail with 15 octets", 32'(rd_cell_avail), 0);
    for (int i = 0; i < 15; i++) rget(pat(14, i), "R7");
    ridle();
    settle();

    // R8: read while empty has no effect
    repeat (3) begin
      @(negedge rd_clk); rd_en = 1;
    end
    ridle();
    wcell(15, 16, 1);
    settle();
    rcell(15, 16, "R8");
    settle();

    // Sweep of cell sizes with pointer wrap: R3, R4, R6
    for (int sz = 16; sz <= 64; sz += 4) begin
      cell_size = 8'(sz);
      @(negedge wr_clk);
      chk("R6", "room empty", 32'(wr_room), 1);
      for (int r = 0; r < 4; r++) begin
        wcell(100 + sz + r, sz, 1);
        settle();
        chk("R3", "avail sweep", 32'(rd_cell_avail), 1);
        chk("R6", "room sweep", 32'(wr_room), 32'((DEP - sz) >= sz));
        rcell(100 + sz + r, sz, "R4");
        settle();
        chk("R10", "avail drained", 32'(rd_cell_avail), 0);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule